// File: doc/BRIEF.md
# Weighted Reel Symbol Generator

This block supplies the three reel symbols of a slot game. Every reel owns a 10-bit linear feedback shift register (LFSR) that moves one position left on each step, with the new bit at bit 0 formed from an XOR of two taps. Each reel uses a different tap pair. The value that the register moves to goes through a ladder of eight cumulative upper bounds and comes out as one of nine 4-bit symbol codes. Symbols with narrow ranges come up rarely, and symbols with wide ranges come up often.

The game controller pulses or holds `step_i` to spin the reels. The three symbol outputs are registered. They change only at an edge where `step_i` is high, and they keep their value at every other edge. Each reel's seed is a parameter. Reset loads the seeds, and the outputs then show the symbols of those seeds.

Top module: `reel_gen`

## Requirements
- R1: While `rst_ni` is low, reel k's register holds parameter SEEDk and its output shows the symbol code of SEEDk, following the mapping of R7.
- R2: Reel 0 steps from value v to {v[8:0], v[7]^v[9]}.
- R3: Reel 1 steps from value v to {v[8:0], v[5]^v[8]}.
- R4: Reel 2 steps from value v to {v[8:0], v[3]^v[6]}.
- R5: At an edge where `step_i` is low, no register changes and all three outputs keep their previous codes.
- R6: At an edge where `step_i` is high, every output takes the symbol of its reel's new register value. The output is valid one cycle after `step_i` is sampled.
- R7: A value v maps to a code as follows: 0..20 gives 1 (bar), 21..44 gives 2 (apple), 45..79 gives 3 (melon), 80..119 gives 4 (banana), 120..169 gives 5 (lemon), 170..234 gives 6 (orange), 235..334 gives 7 (guava), 335..524 gives 8 (cherry), and 525..1023 gives 9 (berry).
- R8: Outside reset, every output code is between 1 and 9 inclusive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Advances all three reels at this edge when high |
| sym0_o | output | 4 | Registered symbol code of reel 0 |
| sym1_o | output | 4 | Registered symbol code of reel 1 |
| sym2_o | output | 4 | Registered symbol code of reel 2 |

## Verification
The ladder edges are the hardest part to reach from the ports. Values such as 20/21 or 524/525 turn up only after a long and unpredictable run of steps, or never turn up for a given seed and tap pair. The bench therefore builds six extra instances whose seed parameters sit exactly on both sides of every bound and at the extremes 1 and 1023, and it reads their reset outputs. A scoreboard covers the tap pairs and the gating. It follows the main instance through about two thousand cycles that mix single steps, step bursts and idle stretches.

// File: rtl/reel_pkg.sv
package reel_pkg;

    localparam int LFSR_W     = 10;
    localparam int NUM_REELS  = 3;
    localparam int SYM_W      = 4;
    localparam int NUM_BOUNDS = 8;

    typedef enum logic [SYM_W-1:0] {
        SYM_NONE   = 4'd0,
        SYM_BAR    = 4'd1,
        SYM_APPLE  = 4'd2,
        SYM_MELON  = 4'd3,
        SYM_BANANA = 4'd4,
        SYM_LEMON  = 4'd5,
        SYM_ORANGE = 4'd6,
        SYM_GUAVA  = 4'd7,
        SYM_CHERRY = 4'd8,
        SYM_BERRY  = 4'd9
    } sym_t;

    // Inclusive upper bound of symbol code i+1; above the last bound -> SYM_BERRY
    localparam int unsigned BOUND [NUM_BOUNDS] = '{20, 44, 79, 119, 169, 234, 334, 524};

    // Feedback tap pair per reel
    localparam int TAP_HI [NUM_REELS] = '{9, 8, 6};
    localparam int TAP_LO [NUM_REELS] = '{7, 5, 3};

    function automatic sym_t sym_of(input logic [LFSR_W-1:0] val);
        sym_t res;
        res = SYM_BERRY;
        for (int i = NUM_BOUNDS - 1; i >= 0; i--) begin
            if (32'(val) <= BOUND[i]) begin
                res = sym_t'(SYM_W'(i + 1));
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/reel_lfsr.sv
module reel_lfsr #(
    parameter int              W     = 10,
    parameter int              TAP_A = 9,
    parameter int              TAP_B = 7,
    parameter logic [W-1:0]    SEED  = '1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         adv_i,
    output logic [W-1:0] state_o,
    output logic [W-1:0] next_o
);

    typedef struct packed {
        logic [W-1:0] val;
    } lfsr_st_t;

    lfsr_st_t st_d, st_q;
    logic     fb;

    always_comb begin
        st_d = st_q;
        fb   = st_q.val[TAP_A] ^ st_q.val[TAP_B];
        if (adv_i) begin
            st_d.val = {st_q.val[W-2:0], fb};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.val <= SEED;
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o = st_q.val;
    assign next_o  = st_d.val;

    AST_SHIFT_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        adv_i |=> state_o[W-1:1] == $past(state_o[W-2:0])); // R2

    AST_LFSR_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !adv_i |=> $stable(state_o)); // R5

endmodule

// File: rtl/sym_ladder.sv
module sym_ladder
    import reel_pkg::*;
(
    input  logic [LFSR_W-1:0] val_i,
    output sym_t              sym_o
);

    always_comb begin
        sym_o = sym_of(val_i);
    end

endmodule

// File: rtl/reel_gen.sv
module reel_gen
    import reel_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED0 = 10'h2A5,
    parameter logic [LFSR_W-1:0] SEED1 = 10'h15B,
    parameter logic [LFSR_W-1:0] SEED2 = 10'h3C1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    output logic [SYM_W-1:0] sym0_o,
    output logic [SYM_W-1:0] sym1_o,
    output logic [SYM_W-1:0] sym2_o
);

    localparam logic [LFSR_W-1:0] SEEDS [NUM_REELS] = '{SEED0, SEED1, SEED2};

    typedef struct packed {
        sym_t [NUM_REELS-1:0] sym;
    } out_st_t;

    out_st_t st_d, st_q;

    logic [LFSR_W-1:0] reel_val  [NUM_REELS];
    logic [LFSR_W-1:0] reel_next [NUM_REELS];
    sym_t              reel_sym  [NUM_REELS];

    for (genvar r = 0; r < NUM_REELS; r++) begin : g_reel
        reel_lfsr #(
            .W     (LFSR_W),
            .TAP_A (TAP_HI[r]),
            .TAP_B (TAP_LO[r]),
            .SEED  (SEEDS[r])
        ) u_lfsr (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .adv_i   (step_i),
            .state_o (reel_val[r]),
            .next_o  (reel_next[r])
        );

        sym_ladder u_ladder (
            .val_i (reel_next[r]),
            .sym_o (reel_sym[r])
        );
    end

    always_comb begin
        st_d = st_q;
        if (step_i) begin
            for (int r = 0; r < NUM_REELS; r++) begin
                st_d.sym[r] = reel_sym[r];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int r = 0; r < NUM_REELS; r++) begin
                st_q.sym[r] <= sym_of(SEEDS[r]);
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign sym0_o = st_q.sym[0];
    assign sym1_o = st_q.sym[1];
    assign sym2_o = st_q.sym[2];

    AST_SYM_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !step_i |=> $stable({sym0_o, sym1_o, sym2_o})); // R5

    AST_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sym0_o != 4'd0 && sym0_o <= 4'd9) && (sym1_o != 4'd0 && sym1_o <= 4'd9)
        && (sym2_o != 4'd0 && sym2_o <= 4'd9)); // R8

    AST_REEL_DIVERGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_i |=> (reel_val[0][0] == ($past(reel_val[0][7]) ^ $past(reel_val[0][9])))); // R2

endmodule

// File: tb/tb_reel_gen.sv
module tb_reel_gen;

    localparam logic [9:0] S0 = 10'h2A5;
    localparam logic [9:0] S1 = 10'h15B;
    localparam logic [9:0] S2 = 10'h3C1;

    // Boundary seeds and their expected codes (R7)
    localparam int BV [18] = '{1, 20, 21, 44, 45, 79, 80, 119, 120, 169,
                               170, 234, 235, 334, 335, 524, 525, 1023};
    localparam int BC [18] = '{1, 1, 2, 2, 3, 3, 4, 4, 5, 5,
                               6, 6, 7, 7, 8, 8, 9, 9};

    logic       clk   = 1'b0;
    logic       rst_n = 1'b0;
    logic       step  = 1'b0;
    logic [3:0] s0, s1, s2;
    logic [3:0] bs [6][3];

    always #4 clk = ~clk;

    reel_gen #(.SEED0(S0), .SEED1(S1), .SEED2(S2)) dut (
        .clk_i (clk), .rst_ni (rst_n), .step_i (step),
        .sym0_o (s0), .sym1_o (s1), .sym2_o (s2)
    );

    for (genvar g = 0; g < 6; g++) begin : g_bnd
        reel_gen #(
            .SEED0 (10'(BV[3*g])),
            .SEED1 (10'(BV[3*g+1])),
            .SEED2 (10'(BV[3*g+2]))
        ) u_b (
            .clk_i (clk), .rst_ni (rst_n), .step_i (1'b0),
            .sym0_o (bs[g][0]), .sym1_o (bs[g][1]), .sym2_o (bs[g][2])
        );
    end

    int tests = 0;
    int fails = 0;
    logic [9:0]  m [3];
    logic [12:0] expq [$];
    string step_tag [3] = '{"R2 R6", "R3 R6", "R4 R6"};

    function automatic logic [3:0] exp_sym(input logic [9:0] v);
        if (v <= 20)  return 4'd1;
        if (v <= 44)  return 4'd2;
        if (v <= 79)  return 4'd3;
        if (v <= 119) return 4'd4;
        if (v <= 169) return 4'd5;
        if (v <= 234) return 4'd6;
        if (v <= 334) return 4'd7;
        if (v <= 524) return 4'd8;
        return 4'd9;
    endfunction

    function automatic logic [9:0] adv(input int r, input logic [9:0] v);
        logic fb;
        case (r)
            0:       fb = v[7] ^ v[9];
            1:       fb = v[5] ^ v[8];
            default: fb = v[3] ^ v[6];
        endcase
        return {v[8:0], fb};
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Driver: one expected item per driven cycle
    task automatic drive(input bit st);
        @(negedge clk);
        step = st;
        if (st) begin
            for (int r = 0; r < 3; r++) m[r] = adv(r, m[r]);
        end
        expq.push_back({st, exp_sym(m[0]), exp_sym(m[1]), exp_sym(m[2])});
    endtask

    // Monitor: compares just after each edge
    always @(posedge clk) begin
        #2;
        if (expq.size() > 0) begin
            logic [12:0] it;
            logic [3:0]  act [3];
            it = expq.pop_front();
            act[0] = s0; act[1] = s1; act[2] = s2;
            for (int r = 0; r < 3; r++) begin
                logic [3:0] e;
                e = it[4*(2-r) +: 4];
                check(it[12] ? step_tag[r] : "R5", act[r], e);
                tests++;
                if (act[r] == 4'd0 || act[r] > 4'd9) begin
                    fails++;
                    $display("FAIL R8 actual=%0d expected=1..9", act[r]);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        tests++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        m[0] = S0; m[1] = S1; m[2] = S2;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", s0, exp_sym(S0));
        check("R1", s1, exp_sym(S1));
        check("R1", s2, exp_sym(S2));
        for (int g = 0; g < 6; g++)
            for (int r = 0; r < 3; r++)
                check("R7 R1", bs[g][r], 4'(BC[3*g+r]));
        rst_n = 1'b1;

        // Mixed stepping: single steps, bursts, idle stretches
        for (int i = 0; i < 1200; i++) drive((i % 5) != 3);
        for (int i = 0; i < 40; i++)   drive(1'b0);
        for (int i = 0; i < 700; i++)  drive(1'b1);
        for (int i = 0; i < 60; i++)   drive((i % 7) == 0);
        drive(1'b0);
        drive(1'b0);
        while (expq.size() > 0) @(negedge clk);

        // R1: reset again mid-run returns seed symbols
        @(negedge clk);
        step  = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", s0, exp_sym(S0));
        check("R1", s1, exp_sym(S1));
        check("R1", s2, exp_sym(S2));
        rst_n = 1'b1;
        m[0] = S0; m[1] = S1; m[2] = S2;
        for (int i = 0; i < 5; i++) drive(1'b1);
        drive(1'b0);
        while (expq.size() > 0) @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule